// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Decoder

This block is the device-side control of a DRAM whose row and column addresses share one set of address pins. It watches the four active-low control pins (row strobe, column strobe, write enable, output enable) and decides what kind of memory cycle the host is running. It does this by comparing each pin with its value one clock earlier, so the clock must run well above the pin toggle rate. From the order in which the strobe and write-enable edges arrive, it picks one of seven cycle types. It then issues internal strobes for row capture, column capture, array read, array write and refresh, and gates the data output enable.

The block holds a 10-bit refresh row counter for refreshes where the column strobe leads the row strobe. It also holds a sticky test-mode flag. A small behavioural storage array stands in for the cell array, so reads and writes can be observed at the ports. Data is carried on separate in and out buses with an output-enable flag rather than a bidirectional pin.

Top module: `dram_cycle_decoder`

## Requirements
- R1: A falling row strobe while the column strobe is high captures the full 10-bit address as the row; rowStb pulses for exactly one clock.
- R2: A falling column strobe while a row is open and write enable is high reads the stored word at (row low 3 bits, address low 3 bits) onto dOut, pulses colStb and rdStb, and sets lastCycle to 1.
- R3: dOutEn is high only while the column strobe is low, output enable is low and the current column cycle produced read data; raising either pin drops it.
- R4: If write enable is already low when the column strobe falls (early write), dIn is stored at that edge, wrStb pulses, lastCycle becomes 2, and dOutEn stays low for that whole column cycle even with output enable low.
- R5: A write-enable fall while the column strobe is low after a read (late write) stores dIn at the captured column, pulses wrStb and sets lastCycle to 3; dOut keeps the earlier read word and dOutEn stays high.
- R6: With the row strobe held low, each new column-strobe fall captures a new column in the same row and reads it.
- R7: A row-strobe low period with no column cycle ends, on the row-strobe rise, in a refresh of the captured row: refStb pulses, refRow shows the row, and lastCycle becomes 4. A row period that contained a column cycle produces no refresh.
- R8: A row-strobe fall while the column strobe is already low refreshes the row held in the counter. refStb pulses, refRow shows that count and lastCycle becomes 5. The address pins are ignored: there is no row capture and no column capture.
- R9: The refresh counter resets to 0, advances by one after each column-before-row refresh, and wraps from 1023 to 0.
- R10: If the column strobe stays low after a read while the row strobe rises and falls again (hidden refresh), a counter refresh is done. lastCycle becomes 6, and dOut and dOutEn keep the read word throughout.
- R11: A column-before-row refresh with write enable low sets lastCycle to 7 and raises testMode. testMode is cleared by a column-before-row refresh with write enable high, or by a row-only refresh.
- R12: After reset all strobes, dOut, dOutEn, refRow, lastCycle and testMode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rowSelN | input | 1 | Row address strobe, active low |
| colSelN | input | 1 | Column address strobe, active low |
| wrEnN | input | 1 | Write enable, active low |
| outEnN | input | 1 | Output enable, active low |
| addrIn | input | 10 | Multiplexed row/column address |
| dIn | input | 4 | Write data |
| dOut | output | 4 | Read data |
| dOutEn | output | 1 | Read data is driven |
| rowStb | output | 1 | One-clock row-capture pulse |
| colStb | output | 1 | One-clock column-capture pulse |
| rdStb | output | 1 | One-clock array-read pulse |
| wrStb | output | 1 | One-clock array-write pulse |
| refStb | output | 1 | One-clock refresh pulse |
| refRow | output | 10 | Row of the latest refresh |
| lastCycle | output | 3 | Latest cycle type (0 none, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh, 7 test entry) |
| testMode | output | 1 | Test-mode flag |

## Verification
A pin change driven between clock edges is seen as an edge at the next rising clock. The strobes, dOut, refRow, lastCycle and testMode all change at that same rising edge. The strobes then stay high for that one clock only. dOutEn follows the column-strobe and output-enable pins directly, combined with read-valid state that is also set at that edge. The bench therefore drives every pin on a falling clock edge and checks on the next falling edge. A strobe missing from that window, or present in any other window, is caught.

// File: rtl/dram_dec_pkg.sv
`timescale 1ns/1ps
package dram_dec_pkg;

  typedef enum logic [2:0] {
    CYC_NONE        = 3'd0,
    CYC_READ        = 3'd1,
    CYC_EARLY_WR    = 3'd2,
    CYC_LATE_WR     = 3'd3,
    CYC_ROW_REFRESH = 3'd4,
    CYC_CBR         = 3'd5,
    CYC_HIDDEN      = 3'd6,
    CYC_TEST_ENTRY  = 3'd7
  } cycKind_t;

  typedef struct packed {
    logic rowLatch;
    logic colLatch;
    logic arrRead;
    logic arrWrite;
    logic cntRefresh;
    logic rowRefresh;
  } strobes_t;

endpackage

// File: rtl/dram_dec_ctrl.sv
`timescale 1ns/1ps
module dram_dec_ctrl
  import dram_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rowSelN,
  input  logic       colSelN,
  input  logic       wrEnN,
  input  logic       outEnN,
  output strobes_t   stb,
  output logic       wrLatchedCol,
  output strobes_t   stbQ,
  output logic [2:0] lastCycle,
  output logic       testMode,
  output logic       dOutEn
);

  // previous pin samples for edge detection
  logic prevRas, prevCas, prevWe;
  logic rasFall, rasRise, casFall, casRise, weFall;

  // cycle state
  logic rowActive;   // a normal row is open
  logic colSeen;     // a column cycle happened in this row period
  logic colActive;   // current column-strobe low period is a column cycle
  logic earlyWr;     // current column cycle is an early write
  logic readValid;   // current column-strobe low period carries read data
  cycKind_t lastKind, nextKind;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRas <= 1'b1;
      prevCas <= 1'b1;
      prevWe  <= 1'b1;
    end else begin
      prevRas <= rowSelN;
      prevCas <= colSelN;
      prevWe  <= wrEnN;
    end
  end

  assign rasFall = prevRas & ~rowSelN;
  assign rasRise = ~prevRas & rowSelN;
  assign casFall = prevCas & ~colSelN;
  assign casRise = ~prevCas & colSelN;
  assign weFall  = prevWe & ~wrEnN;

  // cycle classification
  always_comb begin
    stb          = '0;
    wrLatchedCol = 1'b0;
    nextKind     = lastKind;
    if (rasFall) begin
      if (!colSelN) begin
        stb.cntRefresh = 1'b1;
        if (!wrEnN)         nextKind = CYC_TEST_ENTRY;
        else if (readValid) nextKind = CYC_HIDDEN;
        else                nextKind = CYC_CBR;
      end else begin
        stb.rowLatch = 1'b1;
      end
    end
    if (rasRise && rowActive && !colSeen) begin
      stb.rowRefresh = 1'b1;
      nextKind       = CYC_ROW_REFRESH;
    end
    if (casFall && rowActive && !rowSelN) begin
      stb.colLatch = 1'b1;
      if (!wrEnN) begin
        stb.arrWrite = 1'b1;
        nextKind     = CYC_EARLY_WR;
      end else begin
        stb.arrRead = 1'b1;
        nextKind    = CYC_READ;
      end
    end
    if (weFall && !casFall && !colSelN && colActive && !earlyWr &&
        rowActive && !rowSelN) begin
      stb.arrWrite = 1'b1;
      wrLatchedCol = 1'b1;
      nextKind     = CYC_LATE_WR;
    end
  end

  // row period state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowActive <= 1'b0;
      colSeen   <= 1'b0;
    end else if (rasRise) begin
      rowActive <= 1'b0;
      colSeen   <= 1'b0;
    end else if (stb.rowLatch) begin
      rowActive <= 1'b1;
      colSeen   <= 1'b0;
    end else if (stb.colLatch) begin
      colSeen <= 1'b1;
    end
  end

  // column period state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colActive <= 1'b0;
      earlyWr   <= 1'b0;
      readValid <= 1'b0;
    end else if (casRise) begin
      colActive <= 1'b0;
      earlyWr   <= 1'b0;
      readValid <= 1'b0;
    end else if (casFall) begin
      colActive <= stb.colLatch;
      earlyWr   <= stb.colLatch & ~wrEnN;
      readValid <= stb.arrRead;
    end
  end

  // test mode flag, cycle type and registered strobe copies
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testMode <= 1'b0;
      lastKind <= CYC_NONE;
      stbQ     <= '0;
    end else begin
      if (stb.cntRefresh && !wrEnN)
        testMode <= 1'b1;
      else if ((stb.cntRefresh && wrEnN) || stb.rowRefresh)
        testMode <= 1'b0;
      lastKind <= nextKind;
      stbQ     <= stb;
    end
  end

  assign lastCycle = lastKind;
  assign dOutEn    = readValid & ~colSelN & ~outEnN;

  // R1/R8: at most one row-level or column-level action per clock
  p_one_action_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rowLatch, stb.colLatch, stb.cntRefresh, stb.rowRefresh}));

  // R4: an early write leaves the outputs off
  p_early_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.colLatch && stb.arrWrite) |=> !dOutEn);

  // R5: a late write keeps the outputs driven while the pins still ask for it
  p_late_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrLatchedCol && !outEnN) |=> (dOutEn || colSelN || outEnN));

  // R11: write-enable low at a counter refresh enters test mode
  p_test_entry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntRefresh && !wrEnN) |=> (testMode && lastCycle == 3'd7));

  // R8: a counter refresh never captures a column in the same clock
  p_cbr_no_col_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntRefresh |-> !stb.arrRead && !stb.arrWrite);

endmodule

// File: rtl/dram_dec_dpath.sv
`timescale 1ns/1ps
module dram_dec_dpath
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 4,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic              wrLatchedCol,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic [ADDR_W-1:0] refRow
);

  localparam int IDX_W = ROW_IDX_W + COL_IDX_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0]    rowReg;
  logic [COL_IDX_W-1:0] colReg;
  logic [ADDR_W-1:0]    refCnt;
  logic [DATA_W-1:0]    dOutQ;
  logic [ADDR_W-1:0]    refRowQ;
  logic [IDX_W-1:0]     pinIdx, latchIdx, wrIdx;
  logic [DATA_W-1:0]    cells [DEPTH];

  assign pinIdx   = {rowReg[ROW_IDX_W-1:0], addrIn[COL_IDX_W-1:0]};
  assign latchIdx = {rowReg[ROW_IDX_W-1:0], colReg};
  assign wrIdx    = wrLatchedCol ? latchIdx : pinIdx;

  // address capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowReg <= '0;
      colReg <= '0;
    end else begin
      if (stb.rowLatch) rowReg <= addrIn;
      if (stb.colLatch) colReg <= addrIn[COL_IDX_W-1:0];
    end
  end

  // refresh counter and refreshed-row report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      refRowQ <= '0;
    end else if (stb.cntRefresh) begin
      refRowQ <= refCnt;
      refCnt  <= refCnt + 1'b1;
    end else if (stb.rowRefresh) begin
      refRowQ <= rowReg;
    end
  end

  // read data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dOutQ <= '0;
    else if (stb.arrRead) dOutQ <= cells[pinIdx];
  end

  // behavioural storage
  always_ff @(posedge clk) begin
    if (stb.arrWrite) cells[wrIdx] <= dIn;
  end

  assign dOut   = dOutQ;
  assign refRow = refRowQ;

  // R9: the counter moves by one per counter refresh
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntRefresh |=> refCnt == $past(refCnt) + 1'b1);

  // R9: the counter holds otherwise
  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntRefresh |=> $stable(refCnt));

  // R5/R10: read data changes only on an array read
  p_dout_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.arrRead |=> $stable(dOutQ));

endmodule

// File: rtl/dram_cycle_decoder.sv
`timescale 1ns/1ps
module dram_cycle_decoder
  import dram_dec_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 4,
  parameter int ROW_IDX_W = 3,
  parameter int COL_IDX_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowSelN,
  input  logic              colSelN,
  input  logic              wrEnN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOutEn,
  output logic              rowStb,
  output logic              colStb,
  output logic              rdStb,
  output logic              wrStb,
  output logic              refStb,
  output logic [ADDR_W-1:0] refRow,
  output logic [2:0]        lastCycle,
  output logic              testMode
);

  strobes_t stb, stbQ;
  logic     wrLatchedCol;

  dram_dec_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rowSelN      (rowSelN),
    .colSelN      (colSelN),
    .wrEnN        (wrEnN),
    .outEnN       (outEnN),
    .stb          (stb),
    .wrLatchedCol (wrLatchedCol),
    .stbQ         (stbQ),
    .lastCycle    (lastCycle),
    .testMode     (testMode),
    .dOutEn       (dOutEn)
  );

  dram_dec_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ROW_IDX_W (ROW_IDX_W),
    .COL_IDX_W (COL_IDX_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .wrLatchedCol (wrLatchedCol),
    .addrIn       (addrIn),
    .dIn          (dIn),
    .dOut         (dOut),
    .refRow       (refRow)
  );

  assign rowStb = stbQ.rowLatch;
  assign colStb = stbQ.colLatch;
  assign rdStb  = stbQ.arrRead;
  assign wrStb  = stbQ.arrWrite;
  assign refStb = stbQ.cntRefresh | stbQ.rowRefresh;

endmodule

// File: tb/dram_cycle_decoder_bench.sv
`timescale 1ns/1ps
module dram_cycle_decoder_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dOut;
  logic dOutEn, rowStb, colStb, rdStb, wrStb, refStb, testMode;
  logic [9:0] refRow;
  logic [2:0] lastCycle;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int expCnt = 0;
  logic [3:0] model [64];

  always #2.5 clk = ~clk;

  dram_cycle_decoder u_dram_cycle_decoder (
    .clk(clk), .rstN(rstN), .rowSelN(ras), .colSelN(cas), .wrEnN(we),
    .outEnN(oe), .addrIn(addr), .dIn(din), .dOut(dOut), .dOutEn(dOutEn),
    .rowStb(rowStb), .colStb(colStb), .rdStb(rdStb), .wrStb(wrStb),
    .refStb(refStb), .refRow(refRow), .lastCycle(lastCycle),
    .testMode(testMode)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int idx(input logic [9:0] row, input logic [9:0] col);
    return {row[2:0], col[2:0]};
  endfunction

  task automatic tResetState();
    chk("R12 dOut", dOut, 0);
    chk("R12 dOutEn", dOutEn, 0);
    chk("R12 strobes", {rowStb, colStb, rdStb, wrStb, refStb}, 0);
    chk("R12 refRow", refRow, 0);
    chk("R12 lastCycle", lastCycle, 0);
    chk("R12 testMode", testMode, 0);
  endtask

  task automatic tEarlyWrite(input logic [9:0] row, input logic [9:0] col,
                             input logic [3:0] data);
    addr = row; ras = 0; tick();
    chk("R1 rowStb", rowStb, 1);
    tick();
    chk("R1 rowStb single pulse", rowStb, 0);
    we = 0; din = data; tick();
    addr = col; cas = 0; oe = 0; tick();
    chk("R4 wrStb", wrStb, 1);
    chk("R4 rdStb", rdStb, 0);
    chk("R4 dOutEn", dOutEn, 0);
    chk("R4 lastCycle", lastCycle, 2);
    model[idx(row, col)] = data;
    tick();
    chk("R4 dOutEn held off", dOutEn, 0);
    cas = 1; we = 1; oe = 1; tick();
    ras = 1; tick();
    chk("R7 no refresh after column cycle", refStb, 0);
  endtask

  task automatic tRead(input logic [9:0] row, input logic [9:0] col);
    addr = row; ras = 0; tick();
    chk("R1 rowStb", rowStb, 1);
    addr = col; cas = 0; oe = 0; tick();
    chk("R2 colStb", colStb, 1);
    chk("R2 rdStb", rdStb, 1);
    chk("R2 dOut", dOut, model[idx(row, col)]);
    chk("R2 lastCycle", lastCycle, 1);
    chk("R3 dOutEn on", dOutEn, 1);
    oe = 1; tick();
    chk("R3 dOutEn off by output enable", dOutEn, 0);
    oe = 0; cas = 1; tick();
    chk("R3 dOutEn off by column strobe", dOutEn, 0);
    oe = 1; ras = 1; tick();
  endtask

  task automatic tFastPage(input logic [9:0] row);
    addr = row; ras = 0; tick();
    for (int c = 0; c < 4; c++) begin
      addr = 10'(c); cas = 0; oe = 0; tick();
      chk("R6 colStb", colStb, 1);
      chk("R6 no new row", rowStb, 0);
      chk("R6 dOut", dOut, model[idx(row, 10'(c))]);
      chk("R6 dOutEn", dOutEn, 1);
      cas = 1; oe = 1; tick();
    end
    ras = 1; tick();
  endtask

  task automatic tLateWrite(input logic [9:0] row, input logic [9:0] col,
                            input logic [3:0] data);
    logic [3:0] old;
    old = model[idx(row, col)];
    addr = row; ras = 0; tick();
    addr = col; cas = 0; oe = 0; tick();
    chk("R5 read before write", dOut, old);
    addr = 10'h3f8; we = 0; din = data; tick();
    chk("R5 wrStb", wrStb, 1);
    chk("R5 lastCycle", lastCycle, 3);
    chk("R5 dOut keeps read word", dOut, old);
    chk("R5 dOutEn stays", dOutEn, 1);
    model[idx(row, col)] = data;
    cas = 1; we = 1; oe = 1; tick();
    ras = 1; tick();
    tRead(row, col);
  endtask

  task automatic tRowOnly(input logic [9:0] row);
    addr = row; ras = 0; tick();
    addr = ~row; tick(); tick();
    chk("R7 no refresh yet", refStb, 0);
    ras = 1; tick();
    chk("R7 refStb", refStb, 1);
    chk("R7 refRow", refRow, row);
    chk("R7 lastCycle", lastCycle, 4);
    tick();
  endtask

  task automatic tCounterRefresh(input bit weLow, input bit doCheck);
    cas = 0; we = weLow ? 1'b0 : 1'b1; tick();
    addr = 10'h2a5; ras = 0; tick();
    if (doCheck) begin
      chk("R8 refStb", refStb, 1);
      chk("R9 refRow is count", refRow, expCnt);
      chk("R8 address ignored", {rowStb, colStb}, 0);
      chk("R8/R11 lastCycle", lastCycle, weLow ? 7 : 5);
      chk("R11 testMode", testMode, weLow ? 1 : 0);
    end
    expCnt = (expCnt + 1) % 1024;
    ras = 1; tick();
    cas = 1; we = 1; tick();
    if (doCheck) chk("R8 no column capture", colStb, 0);
  endtask

  task automatic tHidden(input logic [9:0] row, input logic [9:0] col);
    logic [3:0] word;
    word = model[idx(row, col)];
    addr = row; ras = 0; tick();
    addr = col; cas = 0; oe = 0; tick();
    chk("R10 read word", dOut, word);
    ras = 1; tick();
    chk("R10 dOutEn while row strobe high", dOutEn, 1);
    addr = 10'h155; ras = 0; tick();
    chk("R10 refStb", refStb, 1);
    chk("R10 refRow", refRow, expCnt);
    chk("R10 lastCycle", lastCycle, 6);
    chk("R10 dOut held", dOut, word);
    chk("R10 dOutEn held", dOutEn, 1);
    expCnt = (expCnt + 1) % 1024;
    ras = 1; tick();
    chk("R10 dOut after refresh", dOut, word);
    cas = 1; oe = 1; tick();
  endtask

  task automatic tTestMode();
    tCounterRefresh(1'b1, 1'b1);
    chk("R11 testMode sticks", testMode, 1);
    tCounterRefresh(1'b0, 1'b1);
    chk("R11 cleared by counter refresh", testMode, 0);
    tCounterRefresh(1'b1, 1'b1);
    tRowOnly(10'h0c3);
    chk("R11 cleared by row-only refresh", testMode, 0);
  endtask

  task automatic tWrap();
    while (expCnt != 1023) tCounterRefresh(1'b0, 1'b0);
    tCounterRefresh(1'b0, 1'b1);
    chk("R9 wrapped to zero", expCnt, 0);
    tCounterRefresh(1'b0, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    tResetState();
    rstN = 1; tick();
    tResetState();
    tEarlyWrite(10'h005, 10'h002, 4'h9);
    tEarlyWrite(10'h005, 10'h003, 4'h6);
    tEarlyWrite(10'h005, 10'h000, 4'h3);
    tEarlyWrite(10'h005, 10'h001, 4'hc);
    tEarlyWrite(10'h3a1, 10'h207, 4'ha);
    tRead(10'h005, 10'h002);
    tRead(10'h3a1, 10'h207);
    tFastPage(10'h005);
    tLateWrite(10'h005, 10'h003, 4'h1);
    tRowOnly(10'h2e7);
    tCounterRefresh(1'b0, 1'b1);
    tCounterRefresh(1'b0, 1'b1);
    tHidden(10'h3a1, 10'h207);
    tTestMode();
    tWrap();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule